// File: doc/BRIEF.md
# Filtered Uncore Event Counter

This block counts transactions seen by a shared cache slice. Each clock cycle it can take one transaction record. A record carries a valid strobe, the index of the core or thread it came from, a 3-bit request class, a 5-bit code for where the data came from, and two 11-bit cluster IDs: one for the source and one for the target. A 48-bit counter steps by one for each valid record that survives every filter software has switched on. When no filter is on, every valid record counts.

Five filters can be stacked, and each has its own enable bit:
- a per-core bitmap;
- an exact match on the request class;
- an exact match on the data-source code;
- a masked compare on the source ID;
- a masked compare on the target ID.

A small write/read port gives software the controls it needs. It sets the filters, starts and stops counting, clears the counter, reads the count back and manages a sticky wrap flag. Reads are combinational from the read address.

Top module: `uevt_filter_counter`

## Requirements
- R1: With every filter enable at 0 and counting enabled (control bit 0 = 1), each cycle with `rec_valid` high adds one to the count. A cycle with `rec_valid` low never counts. While control bit 0 is 0 the count holds.
- R2: When the core filter is on (control bit 4), a record counts only if bit `rec_core` of the core bitmap register (offset 0x04) is 1. For example, bitmap 0x3 passes cores 0 and 1 only.
- R3: When the request filter is on (control bit 5), a record counts only if `rec_req` equals the selected class in bits [2:0] at offset 0x08. The classes are 3'b100 read, 3'b101 write, 3'b110 atomic store and 3'b111 atomic non-store.
- R4: A selected request class with bit 2 clear is reserved. While the request filter is on with such a class, no record counts, including one whose `rec_req` equals that class.
- R5: When the data-source filter is on (control bit 6), a record counts only if `rec_dsrc` equals bits [12:8] at offset 0x08. Examples: 5'b01110 is local DRAM, 5'b01111 is cross-die DRAM and 5'b00001 is the local-die cache.
- R6: When the source-ID filter is on (control bit 7), a record counts only if `rec_srcid` equals the compare value in bits [10:0] at offset 0x0C, at every bit where the mask in bits [26:16] is 0. A mask bit of 1 removes that bit from the compare. An ID holds a 6-bit super-cluster number in [10:5] and a 5-bit cluster number in [4:0].
- R7: When the target-ID filter is on (control bit 8), it treats `rec_tgtid` the same way, using offset 0x10 with the compare value in [10:0] and the mask in [26:16].
- R8: When several filters are on, a record counts only if it passes all of them.
- R9: A register write changes the configuration from the next cycle on. A record presented in the same cycle as the write is judged under the old configuration.
- R10: Writing control with bit 1 set makes the count 0 after that clock edge. This wins over an increment in the same cycle. Control bit 1 always reads back as 0.
- R11: An increment from the all-ones count wraps the count to 0 and sets the sticky flag at control bit 2. Writing control with bit 2 = 0 leaves the flag set. Writing control with bit 2 = 1 clears it.
- R12: After reset every register and the count read 0. Readback returns the written fields at their positions and zeros elsewhere. The count appears as its low 32 bits at 0x14 and its upper bits at 0x18.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rec_valid | input | 1 | Transaction record present this cycle |
| rec_core | input | $clog2(CORE_W) | Originating core/thread index |
| rec_req | input | 3 | Request class of the record |
| rec_dsrc | input | 5 | Data-source code of the record |
| rec_srcid | input | 11 | Source cluster ID |
| rec_tgtid | input | 11 | Target cluster ID |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write byte offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 5 | Register read byte offset |
| rd_data | output | 32 | Register read data (combinational) |

## Verification
The bench builds the block with CORE_W = 4 and CNT_W = 8. A counter this narrow reaches all ones after 255 passing records. That makes the wrap, the sticky flag and its write-one clear reachable within a short run. It also means the word at 0x18 can only be checked for reading 0. The four-core bitmap still lets each bit be shown passing and blocking on its own.

// File: rtl/uevt_pkg.sv
package uevt_pkg;

    // record field widths
    localparam int REQ_W  = 3;
    localparam int DSRC_W = 5;
    localparam int ID_W   = 11;
    localparam int CL_W   = 5;              // low cluster part of an ID
    localparam int SCL_W  = ID_W - CL_W;    // high super-cluster part

    // register port
    localparam int ADDR_W = 5;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_CTRL   = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_CORE   = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_TYPE   = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_SRCID  = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_TGTID  = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_CNT_LO = 5'h14;
    localparam logic [ADDR_W-1:0] OFS_CNT_HI = 5'h18;

    // control word layout
    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_CLR_BIT = 1;
    localparam int CTRL_OVF_BIT = 2;
    localparam int CTRL_FEN_LSB = 4;

    // type word and id word layout
    localparam int TYPE_DSRC_LSB = 8;
    localparam int ID_MSK_LSB    = 16;

    // filter slots, also their enable bit order above CTRL_FEN_LSB
    localparam int F_CORE   = 0;
    localparam int F_REQ    = 1;
    localparam int F_DSRC   = 2;
    localparam int F_SRCID  = 3;
    localparam int F_TGTID  = 4;
    localparam int NUM_FILT = 5;

    // request classes: the top bit marks a defined class
    localparam int REQ_CLASS_BIT = REQ_W - 1;

    typedef struct packed {
        logic [ID_W-1:0] cmd;
        logic [ID_W-1:0] msk;   // 1 = bit not compared
    } id_flt_t;

    typedef struct packed {
        logic                count_en;
        logic [NUM_FILT-1:0] flt_en;
        logic [REQ_W-1:0]    req;
        logic [DSRC_W-1:0]   dsrc;
        id_flt_t             src;
        id_flt_t             tgt;
    } cfg_t;

    typedef struct packed {
        logic              valid;
        logic [REQ_W-1:0]  req;
        logic [DSRC_W-1:0] dsrc;
        logic [ID_W-1:0]   srcid;
        logic [ID_W-1:0]   tgtid;
    } rec_t;

    // reserved selections never match
    function automatic logic req_match(input logic [REQ_W-1:0] got,
                                       input logic [REQ_W-1:0] sel);
        return sel[REQ_CLASS_BIT] && (got == sel);
    endfunction

endpackage

// File: rtl/uevt_id_match.sv
module uevt_id_match
    import uevt_pkg::*;
(
    input  logic [ID_W-1:0] id,
    input  id_flt_t         flt,
    output logic            hit
);
    logic [ID_W-1:0] diff;
    logic            scl_hit;
    logic            cl_hit;

    always_comb begin
        diff    = (id ^ flt.cmd) & ~flt.msk;
        scl_hit = ~|diff[ID_W-1:CL_W];
        cl_hit  = ~|diff[CL_W-1:0];
        hit     = scl_hit & cl_hit;
    end
endmodule

// File: rtl/uevt_filter.sv
module uevt_filter
    import uevt_pkg::*;
#(
    parameter  int CORE_W     = 8,
    localparam int CORE_IDX_W = (CORE_W > 1) ? $clog2(CORE_W) : 1
) (
    input  rec_t                  rec,
    input  logic [CORE_IDX_W-1:0] core_idx,
    input  logic [CORE_W-1:0]     core_map,
    input  cfg_t                  cfg,
    output logic                  hit
);
    localparam int MAP_W = 1 << CORE_IDX_W;
    localparam int N_ID  = 2;

    logic [MAP_W-1:0]    map_ext;
    logic [NUM_FILT-1:0] raw;
    logic [NUM_FILT-1:0] pass;
    logic [ID_W-1:0]     id_sel  [N_ID];
    id_flt_t             flt_sel [N_ID];
    logic [N_ID-1:0]     id_hit;

    assign id_sel[0]  = rec.srcid;
    assign id_sel[1]  = rec.tgtid;
    assign flt_sel[0] = cfg.src;
    assign flt_sel[1] = cfg.tgt;

    for (genvar g = 0; g < N_ID; g++) begin : g_id
        uevt_id_match u_match (
            .id  (id_sel[g]),
            .flt (flt_sel[g]),
            .hit (id_hit[g])
        );
    end

    always_comb begin
        map_ext              = '0;
        map_ext[CORE_W-1:0]  = core_map;
        raw                  = '0;
        raw[F_CORE]          = map_ext[core_idx];
        raw[F_REQ]           = req_match(rec.req, cfg.req);
        raw[F_DSRC]          = (rec.dsrc == cfg.dsrc);
        raw[F_SRCID]         = id_hit[0];
        raw[F_TGTID]         = id_hit[1];
        // a filter that is off always passes
        pass                 = raw | ~cfg.flt_en;
        hit                  = rec.valid & (&pass);
    end
endmodule

// File: rtl/uevt_count_reg.sv
module uevt_count_reg #(
    parameter int CNT_W = 48
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             clr,
    input  logic             ovf_clr,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);
    logic wrap;

    assign wrap = inc & ~clr & (&cnt);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // set wins over a clear request in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            ovf <= 1'b0;
        end else if (wrap) begin
            ovf <= 1'b1;
        end else if (ovf_clr) begin
            ovf <= 1'b0;
        end
    end
endmodule

// File: rtl/uevt_regs.sv
module uevt_regs
    import uevt_pkg::*;
#(
    parameter int CORE_W = 8,
    parameter int CNT_W  = 48
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              ovf,
    output cfg_t              cfg,
    output logic [CORE_W-1:0] core_map,
    output logic              clr_pulse,
    output logic              ovf_clr_pulse
);
    localparam int EXT_W = 2 * DATA_W;

    logic              ctrl_wr;
    logic [EXT_W-1:0]  cnt_ext;
    logic [DATA_W-1:0] core_ext;
    logic              unused_wr;

    assign ctrl_wr       = wr_en && (wr_addr == OFS_CTRL);
    assign clr_pulse     = ctrl_wr && wr_data[CTRL_CLR_BIT];
    assign ovf_clr_pulse = ctrl_wr && wr_data[CTRL_OVF_BIT];
    assign unused_wr     = ^wr_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg      <= '0;
            core_map <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                OFS_CTRL: begin
                    cfg.count_en <= wr_data[CTRL_EN_BIT];
                    cfg.flt_en   <= wr_data[CTRL_FEN_LSB +: NUM_FILT];
                end
                OFS_CORE:  core_map  <= wr_data[CORE_W-1:0];
                OFS_TYPE: begin
                    cfg.req  <= wr_data[REQ_W-1:0];
                    cfg.dsrc <= wr_data[TYPE_DSRC_LSB +: DSRC_W];
                end
                OFS_SRCID: begin
                    cfg.src.cmd <= wr_data[ID_W-1:0];
                    cfg.src.msk <= wr_data[ID_MSK_LSB +: ID_W];
                end
                OFS_TGTID: begin
                    cfg.tgt.cmd <= wr_data[ID_W-1:0];
                    cfg.tgt.msk <= wr_data[ID_MSK_LSB +: ID_W];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        cnt_ext              = '0;
        cnt_ext[CNT_W-1:0]   = cnt;
        core_ext             = '0;
        core_ext[CORE_W-1:0] = core_map;
        rd_data              = '0;
        case (rd_addr)
            OFS_CTRL: begin
                rd_data[CTRL_EN_BIT]                 = cfg.count_en;
                rd_data[CTRL_OVF_BIT]                = ovf;
                rd_data[CTRL_FEN_LSB +: NUM_FILT]    = cfg.flt_en;
            end
            OFS_CORE: rd_data = core_ext;
            OFS_TYPE: begin
                rd_data[REQ_W-1:0]                   = cfg.req;
                rd_data[TYPE_DSRC_LSB +: DSRC_W]     = cfg.dsrc;
            end
            OFS_SRCID: begin
                rd_data[ID_W-1:0]                    = cfg.src.cmd;
                rd_data[ID_MSK_LSB +: ID_W]          = cfg.src.msk;
            end
            OFS_TGTID: begin
                rd_data[ID_W-1:0]                    = cfg.tgt.cmd;
                rd_data[ID_MSK_LSB +: ID_W]          = cfg.tgt.msk;
            end
            OFS_CNT_LO: rd_data = cnt_ext[DATA_W-1:0];
            OFS_CNT_HI: rd_data = cnt_ext[EXT_W-1:DATA_W];
            default:    rd_data = '0;
        endcase
    end
endmodule

// File: rtl/uevt_filter_counter.sv
module uevt_filter_counter
    import uevt_pkg::*;
#(
    parameter  int CORE_W     = 8,
    parameter  int CNT_W      = 48,
    localparam int CORE_IDX_W = (CORE_W > 1) ? $clog2(CORE_W) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rec_valid,
    input  logic [CORE_IDX_W-1:0] rec_core,
    input  logic [REQ_W-1:0]      rec_req,
    input  logic [DSRC_W-1:0]     rec_dsrc,
    input  logic [ID_W-1:0]       rec_srcid,
    input  logic [ID_W-1:0]       rec_tgtid,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [ADDR_W-1:0]     rd_addr,
    output logic [DATA_W-1:0]     rd_data
);
    rec_t              rec;
    cfg_t              cfg;
    logic [CORE_W-1:0] core_map;
    logic              flt_hit;
    logic              inc;
    logic              clr_pulse;
    logic              ovf_clr_pulse;
    logic [CNT_W-1:0]  cnt_q;
    logic              ovf_q;

    always_comb begin
        rec.valid = rec_valid;
        rec.req   = rec_req;
        rec.dsrc  = rec_dsrc;
        rec.srcid = rec_srcid;
        rec.tgtid = rec_tgtid;
    end

    uevt_regs #(.CORE_W(CORE_W), .CNT_W(CNT_W)) u_regs (
        .clk           (clk),
        .rst           (rst),
        .wr_en         (wr_en),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .rd_addr       (rd_addr),
        .rd_data       (rd_data),
        .cnt           (cnt_q),
        .ovf           (ovf_q),
        .cfg           (cfg),
        .core_map      (core_map),
        .clr_pulse     (clr_pulse),
        .ovf_clr_pulse (ovf_clr_pulse)
    );

    uevt_filter #(.CORE_W(CORE_W)) u_filter (
        .rec      (rec),
        .core_idx (rec_core),
        .core_map (core_map),
        .cfg      (cfg),
        .hit      (flt_hit)
    );

    assign inc = flt_hit & cfg.count_en;

    uevt_count_reg #(.CNT_W(CNT_W)) u_count (
        .clk     (clk),
        .rst     (rst),
        .inc     (inc),
        .clr     (clr_pulse),
        .ovf_clr (ovf_clr_pulse),
        .cnt     (cnt_q),
        .ovf     (ovf_q)
    );
endmodule

// File: rtl/uevt_filter_counter_chk.sv
module uevt_filter_counter_chk
    import uevt_pkg::*;
#(
    parameter int CNT_W = 48
) (
    input logic                clk,
    input logic                rst,
    input logic                rec_valid,
    input logic                hit,
    input logic                count_en,
    input logic [NUM_FILT-1:0] flt_en,
    input logic [REQ_W-1:0]    cfg_req,
    input logic                clr,
    input logic                ovf_clr,
    input logic [CNT_W-1:0]    cnt,
    input logic                ovf
);
    a_r1_invalid_never_hits: assert property (@(posedge clk) disable iff (rst)
        !rec_valid |-> !hit);

    a_r1_all_off_passes: assert property (@(posedge clk) disable iff (rst)
        (flt_en == '0 && rec_valid) |-> hit);

    a_r1_hold_when_off: assert property (@(posedge clk) disable iff (rst)
        (!clr && !count_en) |=> $stable(cnt));

    a_r1_step_by_one: assert property (@(posedge clk) disable iff (rst)
        (!clr && count_en && hit) |=> (cnt == $past(cnt) + CNT_W'(1)));

    a_r4_reserved_blocks: assert property (@(posedge clk) disable iff (rst)
        (flt_en[F_REQ] && !cfg_req[REQ_CLASS_BIT]) |-> !hit);

    a_r10_clear_zeroes: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0));

    a_r11_wrap_sets_flag: assert property (@(posedge clk) disable iff (rst)
        (!clr && count_en && hit && (&cnt)) |=> (ovf && cnt == '0));

    a_r11_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovf && !ovf_clr) |=> ovf);
endmodule

bind uevt_filter_counter uevt_filter_counter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rec_valid (rec_valid),
    .hit       (flt_hit),
    .count_en  (cfg.count_en),
    .flt_en    (cfg.flt_en),
    .cfg_req   (cfg.req),
    .clr       (clr_pulse),
    .ovf_clr   (ovf_clr_pulse),
    .cnt       (cnt_q),
    .ovf       (ovf_q)
);

// File: tb/uevt_filter_counter_tb.sv
`timescale 1ns/1ps
module uevt_filter_counter_tb;
    localparam int CORE_W = 4;
    localparam int CNT_W  = 8;

    localparam logic [4:0] A_CTRL = 5'h00, A_CORE = 5'h04, A_TYPE = 5'h08,
                           A_SRC  = 5'h0C, A_TGT  = 5'h10, A_LO   = 5'h14,
                           A_HI   = 5'h18;
    localparam logic [31:0] EN = 32'h1, CLR = 32'h2, OVF = 32'h4,
                            FE_CORE = 32'h10, FE_REQ = 32'h20, FE_DSRC = 32'h40,
                            FE_SRC = 32'h80, FE_TGT = 32'h100;
    localparam logic [2:0] RQ_RD = 3'b100, RQ_WR = 3'b101,
                           RQ_AST = 3'b110, RQ_ANS = 3'b111;
    localparam logic [4:0] DS_DIE_L3 = 5'b00001, DS_XDIE_L3 = 5'b01000,
                           DS_DRAM = 5'b01110, DS_XDIE_DRAM = 5'b01111,
                           DS_XSKT_DRAM = 5'b10000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rec_valid = 1'b0;
    logic [1:0]  rec_core = '0;
    logic [2:0]  rec_req = '0;
    logic [4:0]  rec_dsrc = '0;
    logic [10:0] rec_srcid = '0;
    logic [10:0] rec_tgtid = '0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [4:0]  rd_addr = '0;
    logic [31:0] rd_data;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    uevt_filter_counter #(.CORE_W(CORE_W), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst(rst), .rec_valid(rec_valid), .rec_core(rec_core),
        .rec_req(rec_req), .rec_dsrc(rec_dsrc), .rec_srcid(rec_srcid),
        .rec_tgtid(rec_tgtid), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=0x%08h exp=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic rd_check(input string req, input logic [4:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic put_rec(input logic v, input logic [1:0] c, input logic [2:0] rq,
                           input logic [4:0] ds, input logic [10:0] s, input logic [10:0] t);
        rec_valid = v; rec_core = c; rec_req = rq;
        rec_dsrc = ds; rec_srcid = s; rec_tgtid = t;
    endtask

    task automatic send(input logic v, input logic [1:0] c, input logic [2:0] rq,
                        input logic [4:0] ds, input logic [10:0] s, input logic [10:0] t);
        @(negedge clk);
        put_rec(v, c, rq, ds, s, t);
        @(negedge clk);
        rec_valid = 1'b0;
    endtask

    task automatic t_reset();
        rd_check("R12 ctrl after reset", A_CTRL, 32'h0);
        rd_check("R12 core map after reset", A_CORE, 32'h0);
        rd_check("R12 srcid after reset", A_SRC, 32'h0);
        rd_check("R12 count lo after reset", A_LO, 32'h0);
        rd_check("R12 count hi after reset", A_HI, 32'h0);
        wr(A_CORE, 32'hFFFF_FFFF);
        rd_check("R12 core map width", A_CORE, 32'h0000_000F);
        wr(A_TYPE, 32'hFFFF_EE04);
        rd_check("R12 type fields", A_TYPE, 32'h0000_0E04);
        wr(A_TGT, 32'hFFFF_F123);
        rd_check("R12 tgtid fields", A_TGT, 32'h07FF_0123);
        wr(A_CTRL, EN | FE_CORE | FE_TGT);
        rd_check("R12 ctrl fields", A_CTRL, EN | FE_CORE | FE_TGT);
        wr(A_CORE, 32'h0); wr(A_TYPE, 32'h0); wr(A_TGT, 32'h0);
    endtask

    task automatic t_all_off();
        wr(A_CTRL, EN | CLR);
        send(1, 0, RQ_RD, DS_DRAM, 11'h001, 11'h002);
        send(1, 3, 3'b000, DS_XSKT_DRAM, 11'h7FF, 11'h000);
        send(1, 2, RQ_ANS, DS_XDIE_L3, 11'h123, 11'h456);
        rd_check("R1 all filters off counts every valid record", A_LO, 32'd3);
        send(0, 0, RQ_RD, DS_DRAM, 11'h0, 11'h0);
        rd_check("R1 invalid record not counted", A_LO, 32'd3);
        wr(A_CTRL, 32'h0);
        send(1, 0, RQ_RD, DS_DRAM, 11'h0, 11'h0);
        send(1, 1, RQ_WR, DS_DRAM, 11'h0, 11'h0);
        rd_check("R1 count holds while disabled", A_LO, 32'd3);
    endtask

    task automatic t_core();
        wr(A_CORE, 32'h3);
        wr(A_CTRL, EN | CLR | FE_CORE);
        for (int i = 0; i < 4; i++) send(1, 2'(i), RQ_RD, DS_DRAM, 11'h0, 11'h0);
        rd_check("R2 bitmap 0x3 passes cores 0 and 1", A_LO, 32'd2);
        wr(A_CORE, 32'h8);
        send(1, 3, RQ_RD, DS_DRAM, 11'h0, 11'h0);
        send(1, 2, RQ_RD, DS_DRAM, 11'h0, 11'h0);
        rd_check("R2 bitmap 0x8 passes core 3 only", A_LO, 32'd3);
    endtask

    task automatic t_req();
        wr(A_TYPE, {24'h0, 5'h0, RQ_WR});
        wr(A_CTRL, EN | CLR | FE_REQ);
        send(1, 0, RQ_RD,  DS_DRAM, 11'h0, 11'h0);
        send(1, 0, RQ_WR,  DS_DRAM, 11'h0, 11'h0);
        send(1, 0, RQ_AST, DS_DRAM, 11'h0, 11'h0);
        send(1, 0, RQ_ANS, DS_DRAM, 11'h0, 11'h0);
        send(1, 0, RQ_WR,  DS_DRAM, 11'h0, 11'h0);
        rd_check("R3 write class counts only writes", A_LO, 32'd2);
        wr(A_TYPE, {24'h0, 5'h0, RQ_ANS});
        send(1, 0, RQ_ANS, DS_DRAM, 11'h0, 11'h0);
        send(1, 0, RQ_AST, DS_DRAM, 11'h0, 11'h0);
        rd_check("R3 atomic non-store class", A_LO, 32'd3);
    endtask

    task automatic t_req_rsv();
        wr(A_TYPE, 32'h0000_0001);
        wr(A_CTRL, EN | CLR | FE_REQ);
        send(1, 0, 3'b001, DS_DRAM, 11'h0, 11'h0);
        send(1, 0, RQ_RD,  DS_DRAM, 11'h0, 11'h0);
        send(1, 0, 3'b000, DS_DRAM, 11'h0, 11'h0);
        rd_check("R4 reserved class matches nothing", A_LO, 32'd0);
    endtask

    task automatic t_dsrc();
        wr(A_TYPE, {19'h0, DS_DRAM, 8'h00});
        wr(A_CTRL, EN | CLR | FE_DSRC);
        send(1, 0, RQ_RD, DS_DRAM,      11'h0, 11'h0);
        send(1, 0, RQ_RD, DS_XDIE_DRAM, 11'h0, 11'h0);
        send(1, 0, RQ_RD, DS_XSKT_DRAM, 11'h0, 11'h0);
        send(1, 0, RQ_RD, DS_DIE_L3,    11'h0, 11'h0);
        send(1, 0, RQ_RD, DS_DRAM,      11'h0, 11'h0);
        rd_check("R5 data source local DRAM only", A_LO, 32'd2);
    endtask

    task automatic t_srcid();
        wr(A_SRC, 32'h0000_0070);   // super-cluster 3, cluster 5'b10000
        wr(A_CTRL, EN | CLR | FE_SRC);
        send(1, 0, RQ_RD, DS_DRAM, 11'h070, 11'h0);
        send(1, 0, RQ_RD, DS_DRAM, 11'h071, 11'h0);
        send(1, 0, RQ_RD, DS_DRAM, 11'h0F0, 11'h0);
        rd_check("R6 exact source id", A_LO, 32'd1);
        wr(A_SRC, 32'h001F_0070);   // ignore cluster bits
        send(1, 0, RQ_RD, DS_DRAM, 11'h07F, 11'h0);
        send(1, 0, RQ_RD, DS_DRAM, 11'h063, 11'h0);
        send(1, 0, RQ_RD, DS_DRAM, 11'h090, 11'h0);
        rd_check("R6 masked cluster bits ignored", A_LO, 32'd3);
    endtask

    task automatic t_tgtid();
        wr(A_TGT, 32'h07E0_0021);   // ignore super-cluster, cluster 5'b00001
        wr(A_CTRL, EN | CLR | FE_TGT);
        send(1, 0, RQ_RD, DS_DRAM, 11'h0, 11'h7C1);
        send(1, 0, RQ_RD, DS_DRAM, 11'h0, 11'h023);
        send(1, 0, RQ_RD, DS_DRAM, 11'h0, 11'h001);
        rd_check("R7 target id with super-cluster masked", A_LO, 32'd2);
    endtask

    task automatic t_combo();
        wr(A_CORE, 32'h2);
        wr(A_TYPE, {19'h0, DS_DIE_L3, 5'h0, RQ_RD});
        wr(A_CTRL, EN | CLR | FE_CORE | FE_REQ | FE_DSRC);
        send(1, 1, RQ_RD, DS_DIE_L3,  11'h0, 11'h0);
        send(1, 0, RQ_RD, DS_DIE_L3,  11'h0, 11'h0);
        send(1, 1, RQ_WR, DS_DIE_L3,  11'h0, 11'h0);
        send(1, 1, RQ_RD, DS_XDIE_L3, 11'h0, 11'h0);
        send(1, 1, RQ_RD, DS_DIE_L3,  11'h0, 11'h0);
        rd_check("R8 all enabled filters must pass", A_LO, 32'd2);
    endtask

    task automatic t_cfg_timing();
        wr(A_CORE, 32'h0);
        wr(A_CTRL, EN | CLR);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = A_CTRL; wr_data = EN | FE_CORE;
        put_rec(1, 0, RQ_RD, DS_DRAM, 11'h0, 11'h0);
        @(negedge clk);
        wr_en = 1'b0; rec_valid = 1'b0;
        rd_check("R9 same-cycle record uses old config", A_LO, 32'd1);
        send(1, 0, RQ_RD, DS_DRAM, 11'h0, 11'h0);
        rd_check("R9 new config applies next cycle", A_LO, 32'd1);
    endtask

    task automatic t_clear();
        wr(A_CTRL, EN | CLR);
        send(1, 0, RQ_RD, DS_DRAM, 11'h0, 11'h0);
        send(1, 0, RQ_RD, DS_DRAM, 11'h0, 11'h0);
        send(1, 0, RQ_RD, DS_DRAM, 11'h0, 11'h0);
        rd_check("R10 count before clear", A_LO, 32'd3);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = A_CTRL; wr_data = EN | CLR;
        put_rec(1, 0, RQ_RD, DS_DRAM, 11'h0, 11'h0);
        @(negedge clk);
        wr_en = 1'b0; rec_valid = 1'b0;
        rd_check("R10 clear beats same-cycle increment", A_LO, 32'd0);
        rd_check("R10 clear bit reads 0", A_CTRL, EN);
        send(1, 0, RQ_RD, DS_DRAM, 11'h0, 11'h0);
        rd_check("R10 counting resumes after clear", A_LO, 32'd1);
    endtask

    task automatic t_ovf();
        wr(A_CTRL, EN | CLR);
        @(negedge clk);
        put_rec(1, 1, RQ_WR, DS_DRAM, 11'h0, 11'h0);
        repeat (255) @(negedge clk);
        rec_valid = 1'b0;
        rd_check("R11 count at all ones", A_LO, 32'd255);
        rd_check("R11 no flag before wrap", A_CTRL, EN);
        send(1, 1, RQ_WR, DS_DRAM, 11'h0, 11'h0);
        rd_check("R11 count wraps to zero", A_LO, 32'd0);
        rd_check("R11 flag set on wrap", A_CTRL, EN | OVF);
        rd_check("R12 upper count word", A_HI, 32'd0);
        send(1, 1, RQ_WR, DS_DRAM, 11'h0, 11'h0);
        rd_check("R11 count after wrap", A_LO, 32'd1);
        rd_check("R11 flag sticky", A_CTRL, EN | OVF);
        wr(A_CTRL, EN);
        rd_check("R11 writing 0 keeps flag", A_CTRL, EN | OVF);
        wr(A_CTRL, EN | OVF);
        rd_check("R11 writing 1 clears flag", A_CTRL, EN);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_all_off();
        t_core();
        t_req();
        t_req_rsv();
        t_dsrc();
        t_srcid();
        t_tgtid();
        t_combo();
        t_cfg_timing();
        t_clear();
        t_ovf();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog act=running exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule